// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This block watches a small set of external interrupt pins, three by default. Each pin has its own edge-polarity select. The raw pin first passes through a synchroniser. An edge is then judged by comparing the synchronised level with the level held one cycle earlier. When an edge of the selected direction is seen, a sticky per-pin flag is set. The flag stays set until software pulses that pin's clear strobe.

Each flagged pin whose enable bit is set raises one of two request lines, high priority or low priority. Some pins are tied to high priority by a parameter mask; by default this is pin 0. Every other pin follows its own priority bit. Any flagged and enabled pin also raises a wake output, so that a sleeping core can resume.

Top module: `ext_irq_unit`

## Requirements
- R1: With polarity bit 1 a 0-to-1 change on a pin sets its flag; with polarity bit 0 a 1-to-0 change sets it. The flag reads 1 at the third rising clock edge after the pin changes and not before.
- R2: A qualifying edge sets the pin's flag whatever the value of the pin's enable bit.
- R3: A pin whose enable bit is 0 contributes nothing to irq_hi_o, irq_lo_o or wake_o, even while its flag is 1.
- R4: A flag stays 1 until its bit in flag_clr_i is 1 at a clock edge; the flag then reads 0 after that edge.
- R5: A pin selected in FIXED_HI_MASK (pin 0 by default) drives irq_hi_o when flagged and enabled, and never drives irq_lo_o, whatever its priority bit.
- R6: Any other flagged and enabled pin drives irq_hi_o when its priority bit is 1 and irq_lo_o when its priority bit is 0.
- R7: wake_o is 1 exactly when at least one pin has both its flag and its enable bit set.
- R8: If a clear strobe and a new qualifying edge on the same pin fall on the same clock edge, the flag ends up 1.
- R9: Changing a polarity bit while the pin level is steady does not set a flag.
- R10: A pin level that is already held while reset is asserted does not set a flag once reset is released.
- R11: An edge in the direction opposite to the selected polarity does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Raw asynchronous interrupt pins |
| rise_sel_i | input | NUM_PINS | Per-pin polarity: 1 selects a rising edge, 0 a falling edge |
| en_i | input | NUM_PINS | Per-pin request enable |
| hi_prio_i | input | NUM_PINS | Per-pin priority: 1 high, 0 low; ignored for pins in FIXED_HI_MASK |
| flag_clr_i | input | NUM_PINS | Per-pin flag clear strobe |
| flag_o | output | NUM_PINS | Sticky per-pin edge flags |
| irq_hi_o | output | 1 | High-priority request |
| irq_lo_o | output | 1 | Low-priority request |
| wake_o | output | 1 | Wake request for a sleeping core |

## Verification
The bench builds the block with its default parameters: three pins, a two-flop synchroniser and pin 0 fixed to high priority. With this small configuration the bench can sweep every combination of pin, polarity, enable and priority. For each combination it computes the expected request, wake and flag values arithmetically. The two-stage synchroniser puts the flag latency at a fixed three cycles, so the bench can time the same-cycle collision of a clear and an edge exactly. The bench also covers the reset-level and polarity-flip cases.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic {
      ROUTE_LO = 1'b0,
      ROUTE_HI = 1'b1
   } route_e;

   function automatic route_e pick_route(input logic fixed_hi, input logic prio);
      return (fixed_hi || prio) ? ROUTE_HI : ROUTE_LO;
   endfunction
endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("eiu_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eiu_edge_flag.sv
module eiu_edge_flag #(
   parameter int ARM_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic rise_sel_i,
   input  logic clr_i,
   output logic flag_o
);
   localparam int CW = $clog2(ARM_CYCLES + 1) + 1;
   localparam logic [CW-1:0] ARM_LAST = CW'(ARM_CYCLES);

   logic [CW-1:0] arm_q;
   logic          armed;
   logic          prev_q;
   logic          hit;
   logic          flag_q;

   assign armed = (arm_q == ARM_LAST);
   // Compare synchronised levels only; the polarity input never feeds prev_q
   assign hit   = armed && (lvl_i != prev_q) && (lvl_i == rise_sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= '0;
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (!armed) arm_q <= arm_q + 1'b1;
         prev_q <= lvl_i;
         flag_q <= hit | (flag_q & ~clr_i);
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/eiu_route.sv
module eiu_route
   import ext_irq_pkg::*;
#(
   parameter int                NUM_PINS      = 3,
   parameter logic [NUM_PINS-1:0] FIXED_HI_MASK = 1
) (
   input  logic [NUM_PINS-1:0] flag_i,
   input  logic [NUM_PINS-1:0] en_i,
   input  logic [NUM_PINS-1:0] hi_prio_i,
   output logic                irq_hi_o,
   output logic                irq_lo_o,
   output logic                wake_o
);
   logic [NUM_PINS-1:0] live;
   logic [NUM_PINS-1:0] to_hi;
   logic [NUM_PINS-1:0] to_lo;

   assign live = flag_i & en_i;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      if (FIXED_HI_MASK[i]) begin : g_fixed
         assign to_hi[i] = live[i];
         assign to_lo[i] = 1'b0;
      end else begin : g_sel
         route_e r;
         assign r        = pick_route(1'b0, hi_prio_i[i]);
         assign to_hi[i] = live[i] && (r == ROUTE_HI);
         assign to_lo[i] = live[i] && (r == ROUTE_LO);
      end
   end

   assign irq_hi_o = |to_hi;
   assign irq_lo_o = |to_lo;
   assign wake_o   = |live;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
   parameter int                  NUM_PINS      = 3,
   parameter int                  SYNC_STAGES   = 2,
   parameter logic [NUM_PINS-1:0] FIXED_HI_MASK = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [NUM_PINS-1:0] rise_sel_i,
   input  logic [NUM_PINS-1:0] en_i,
   input  logic [NUM_PINS-1:0] hi_prio_i,
   input  logic [NUM_PINS-1:0] flag_clr_i,
   output logic [NUM_PINS-1:0] flag_o,
   output logic                irq_hi_o,
   output logic                irq_lo_o,
   output logic                wake_o
);
   localparam int ARM_CYCLES = SYNC_STAGES + 1;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_n
         $error("ext_irq_unit: NUM_PINS out of range");
      end
   endgenerate

   logic [NUM_PINS-1:0] lvl;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_ch
      eiu_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i[i]),
         .q_o   (lvl[i])
      );
      eiu_edge_flag #(.ARM_CYCLES(ARM_CYCLES)) u_flag (
         .clk        (clk),
         .rst_n      (rst_n),
         .lvl_i      (lvl[i]),
         .rise_sel_i (rise_sel_i[i]),
         .clr_i      (flag_clr_i[i]),
         .flag_o     (flag_o[i])
      );
   end

   eiu_route #(.NUM_PINS(NUM_PINS), .FIXED_HI_MASK(FIXED_HI_MASK)) u_route (
      .flag_i    (flag_o),
      .en_i      (en_i),
      .hi_prio_i (hi_prio_i),
      .irq_hi_o  (irq_hi_o),
      .irq_lo_o  (irq_lo_o),
      .wake_o    (wake_o)
   );
endmodule

// File: rtl/eiu_chk.sv
module eiu_chk #(
   parameter int                  NUM_PINS      = 3,
   parameter logic [NUM_PINS-1:0] FIXED_HI_MASK = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] en_i,
   input logic [NUM_PINS-1:0] hi_prio_i,
   input logic [NUM_PINS-1:0] flag_clr_i,
   input logic [NUM_PINS-1:0] flag_o,
   input logic                irq_hi_o,
   input logic                irq_lo_o,
   input logic                wake_o
);
   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_o & en_i) == '0) |-> (!irq_hi_o && !irq_lo_o && !wake_o)); // R3

   AST_WAKE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> ((flag_o & en_i) != '0)); // R7

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_a
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_o[i] && !flag_clr_i[i]) |=> flag_o[i]); // R4
      if (FIXED_HI_MASK[i]) begin : g_fx
         AST_FIXED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && en_i[i]) |-> irq_hi_o); // R5
      end else begin : g_sl
         AST_SEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && en_i[i] && hi_prio_i[i]) |-> irq_hi_o); // R6
         AST_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && en_i[i] && !hi_prio_i[i]) |-> irq_lo_o); // R6
      end
   end
endmodule

bind ext_irq_unit eiu_chk #(.NUM_PINS(NUM_PINS), .FIXED_HI_MASK(FIXED_HI_MASK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_i       (en_i),
   .hi_prio_i  (hi_prio_i),
   .flag_clr_i (flag_clr_i),
   .flag_o     (flag_o),
   .irq_hi_o   (irq_hi_o),
   .irq_lo_o   (irq_lo_o),
   .wake_o     (wake_o)
);

// File: tb/sim_ext_irq_unit.sv
module sim_ext_irq_unit;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin = '0, pol = '1, en = '0, prio = '0, clr = '0;
   logic [N-1:0] flag;
   logic         hi, lo, wk;
   int           errors = 0, checks = 0;
   bit           done = 0;

   always #4 clk = ~clk;

   ext_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .rise_sel_i(pol), .en_i(en),
      .hi_prio_i(prio), .flag_clr_i(clr), .flag_o(flag),
      .irq_hi_o(hi), .irq_lo_o(lo), .wake_o(wk)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic clear_all();
      clr = '1; cyc(1); clr = '0;
   endtask

   initial begin
      // R10: pins held high through reset
      pin = '1; pol = '1;
      cyc(3); rst_n = 1'b1; cyc(8);
      chk("R10 flags after reset with high pins", 32'(flag), 0);
      chk("R10 no request", 32'({hi, lo, wk}), 0);
      pin = '0; cyc(6);
      chk("R11 falling edge with rising polarity", 32'(flag), 0);

      for (int i = 0; i < N; i++)
         for (int p = 0; p < 2; p++)
            for (int e = 0; e < 2; e++)
               for (int q = 0; q < 2; q++) begin
                  logic xh, xl;
                  pol[i] = 1'(p); pin[i] = ~1'(p);
                  cyc(6); clear_all(); cyc(1);
                  chk("R11 opposite edge leaves flag clear", 32'(flag), 0);
                  en = '0; en[i] = 1'(e);
                  prio = '0; prio[i] = 1'(q);
                  pin[i] = 1'(p);
                  cyc(2);
                  chk("R1 flag not yet set after two edges", 32'(flag[i]), 0);
                  cyc(1);
                  chk("R1 R2 flag set on selected edge", 32'(flag), 32'(1 << i));
                  xh = (e != 0) && (i == 0 || q != 0);
                  xl = (e != 0) && (i != 0) && (q == 0);
                  chk(i == 0 ? "R5 high line" : "R6 high line", 32'(hi), 32'(xh));
                  chk(i == 0 ? "R5 low line" : "R6 low line", 32'(lo), 32'(xl));
                  chk(e != 0 ? "R7 wake" : "R3 wake masked", 32'(wk), 32'(e));
                  cyc(4);
                  chk("R4 flag held without clear", 32'(flag[i]), 1);
                  // R8: clear coincides with a new edge
                  pin[i] = ~1'(p); cyc(5);
                  pin[i] = 1'(p); cyc(2);
                  clr[i] = 1'b1; cyc(1); clr[i] = 1'b0;
                  chk("R8 edge wins over clear", 32'(flag[i]), 1);
                  clr[i] = 1'b1; cyc(1); clr[i] = 1'b0;
                  chk("R4 clear drops flag", 32'(flag[i]), 0);
                  chk("R3 R7 no request after clear", 32'({hi, lo, wk}), 0);
                  // R9: flip polarity with steady level
                  pol[i] = ~pol[i]; cyc(6);
                  chk("R9 polarity flip no flag", 32'(flag), 0);
                  pol[i] = ~pol[i]; cyc(6);
                  chk("R9 polarity restore no flag", 32'(flag), 0);
               end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule